// File: doc/BRIEF.md
# Super I/O Configuration Gate

This block guards the configuration space of a legacy Super I/O device that sits behind a pair of byte ports: an index port and a data port. After reset the space is locked. The host opens it by writing a fixed four-byte key to the index port. The final byte of that key depends on which base address the device is strapped to. While the space is open, a byte written to the index port picks a register, and the data port then reads or writes that register.

Registers below 0x30 are global and shared by every function. Registers at 0x30 and above belong to the logical device chosen by a device-number register. Each device keeps an activation flag, a 16-bit I/O base and an option byte. The activation flags and bases go out on ports to the function blocks that use them. Writing the leave code to the configure-control register locks the space again.

The host interface uses one write strobe and one read strobe, with a select line that picks index or data. Read data comes back one cycle after the strobe. The base address is set at build time by a parameter.

Top module: `sio_cfg_gate`

## Requirements
- R1: After synchronous reset the space is locked (`cfg_mode`=0), `clk_div_sel`=0, every `dev_active` bit is 0 and every `dev_base` field is 0x0000.
- R2: Writing 0x87, 0x01, 0x55 and then a final byte to the index port (`port_sel`=0) sets `cfg_mode` on the edge that takes the final byte. The final byte is 0xAA when `BASE_PORT` is 0x004E and 0x55 for any other base, including 0x002E.
- R3: While locked, an index-port write that is not the next expected key byte sends the matcher back to expecting 0x87, even when the byte is itself 0x87. A wrong first byte leaves it waiting for 0x87. Data-port writes do not change the matcher's progress.
- R4: While locked, reads of either port return 0xFF, and data-port writes change no register.
- R5: While open, an index-port write stores the register index, and an index-port read returns it.
- R6: Writing 0x02 to register 0x02 locks the space again on that edge. Any other value written there is ignored. Reading register 0x02 returns 0x00.
- R7: Register 0x07 is an 8-bit read/write device number. Accesses to registers at 0x30 and above reach only the bank of the device it names.
- R8: Register 0x23 stores only bit 0, which drives `clk_div_sel`. Its bits 7..1 read as 0.
- R9: Every other global register (below 0x30) reads 0x00 and ignores writes.
- R10: In each device bank, register 0x30 bit 0 is the activation flag and reads back in bit 0 with the other bits 0. Register 0x60 is the base high byte, 0x61 the base low byte, and 0xF0 an 8-bit option byte. Device i drives `dev_active[i]` and `dev_base[16*i+15:16*i]`.
- R11: Writes to a device's base registers are ignored while that device is active.
- R12: With a device number of `NUM_DEV` or more, or an unmapped index at 0x30 or above, reads return 0x00 and writes have no effect.
- R13: `rd_vld` is high for exactly the cycle after each cycle in which `rd_stb` is high, and `rdata` is valid during that cycle. Back-to-back reads are served one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Byte write strobe |
| rd_stb | input | 1 | Byte read strobe |
| port_sel | input | 1 | 0 = index port, 1 = data port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid with `rd_vld` |
| rd_vld | output | 1 | Read data valid, one cycle after `rd_stb` |
| cfg_mode | output | 1 | Configuration space open |
| clk_div_sel | output | 1 | Serial clock pre-divide choice (0 = default 48 MHz path) |
| dev_active | output | NUM_DEV | Activation flag per logical device |
| dev_base | output | 16*NUM_DEV | I/O base per logical device |

## Verification
The hardest case to reach is the key matcher after a near-miss. A repeated 0x87, or a key broken partway through, must not leave the matcher partly advanced. The stimulus sends broken keys whose later bytes would complete a key if the matcher resumed instead of restarting, and checks that the space stays locked. A second instance strapped to the other base address receives the same writes, so one byte stream shows each base rejecting the other's final key byte. The base-freeze rule needs a device to be active first. The bench activates one device, attempts a base write, then deactivates it, rewrites the base and reactivates it, and checks the port after each step.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    localparam logic [7:0] REG_CFG_CTL  = 8'h02;
    localparam logic [7:0] REG_DEV_NUM  = 8'h07;
    localparam logic [7:0] REG_CLK_SEL  = 8'h23;
    localparam logic [7:0] BANK_FLOOR   = 8'h30;
    localparam logic [7:0] REG_ACTIVATE = 8'h30;
    localparam logic [7:0] REG_BASE_HI  = 8'h60;
    localparam logic [7:0] REG_BASE_LO  = 8'h61;
    localparam logic [7:0] REG_OPTION   = 8'hF0;

    localparam logic [7:0] CFG_LEAVE    = 8'h02;
    localparam logic [7:0] LOCKED_BYTE  = 8'hFF;

    localparam logic [7:0] KEY_FIRST    = 8'h87;
    localparam logic [7:0] KEY_SECOND   = 8'h01;
    localparam logic [7:0] KEY_THIRD    = 8'h55;
    localparam logic [15:0] ALT_BASE    = 16'h004E;

    typedef enum logic [1:0] {
        KS_WAIT0 = 2'd0,
        KS_WAIT1 = 2'd1,
        KS_WAIT2 = 2'd2,
        KS_WAIT3 = 2'd3
    } key_step_e;

    // One register-file access as seen by the global or banked storage
    typedef struct packed {
        logic       wr;
        logic [7:0] idx;
        logic [7:0] wdata;
    } cfg_acc_t;

    typedef struct packed {
        logic        active;
        logic [15:0] base;
        logic [7:0]  opt;
    } dev_cfg_t;

    function automatic logic [7:0] last_key(input logic [15:0] base);
        return (base == ALT_BASE) ? 8'hAA : 8'h55;
    endfunction

    function automatic logic [7:0] key_expect(input key_step_e s, input logic [15:0] base);
        case (s)
            KS_WAIT0: return KEY_FIRST;
            KS_WAIT1: return KEY_SECOND;
            KS_WAIT2: return KEY_THIRD;
            default:  return last_key(base);
        endcase
    endfunction

    function automatic key_step_e step_after(input key_step_e s);
        case (s)
            KS_WAIT0: return KS_WAIT1;
            KS_WAIT1: return KS_WAIT2;
            KS_WAIT2: return KS_WAIT3;
            default:  return KS_WAIT0;
        endcase
    endfunction

    function automatic logic is_banked(input logic [7:0] idx);
        return idx >= BANK_FLOOR;
    endfunction

endpackage

// File: rtl/sio_key_matcher.sv
module sio_key_matcher
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] BASE_PORT = 16'h002E
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    output logic       unlock
);

    key_step_e step_q, step_d;
    logic      hit;

    assign hit = (key_byte == key_expect(step_q, BASE_PORT));

    always_comb begin
        step_d = step_q;
        unlock = 1'b0;
        if (key_wr) begin
            if (!hit) begin
                step_d = KS_WAIT0;
            end else if (step_q == KS_WAIT3) begin
                step_d = KS_WAIT0;
                unlock = 1'b1;
            end else begin
                step_d = step_after(step_q);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= KS_WAIT0;
        else     step_q <= step_d;
    end

    // R3: a wrong byte always returns the matcher to the first key byte
    assert_restart_on_miss_R3: assert property (@(posedge clk) disable iff (rst)
        (key_wr && !hit) |=> (step_q == KS_WAIT0));

    // R3: with no index write the matcher holds its position
    assert_hold_without_write_R3: assert property (@(posedge clk) disable iff (rst)
        !key_wr |=> $stable(step_q));

endmodule

// File: rtl/sio_global_regs.sv
module sio_global_regs
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cfg_acc_t   acc,
    output logic [7:0] dev_num,
    output logic       clk_sel,
    output logic       leave,
    output logic [7:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_num <= '0;
            clk_sel <= 1'b0;
        end else if (acc.wr) begin
            case (acc.idx)
                REG_DEV_NUM: dev_num <= acc.wdata;
                REG_CLK_SEL: clk_sel <= acc.wdata[0];
                default: ;
            endcase
        end
    end

    assign leave = acc.wr && (acc.idx == REG_CFG_CTL) && (acc.wdata == CFG_LEAVE);

    always_comb begin
        case (acc.idx)
            REG_DEV_NUM: rd_data = dev_num;
            REG_CLK_SEL: rd_data = {7'd0, clk_sel};
            default:     rd_data = 8'h00;
        endcase
    end

    // R7: the device number only moves on a global write
    assert_devnum_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !acc.wr |=> $stable(dev_num));

    // R8: the clock choice only moves on a global write
    assert_clksel_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !acc.wr |=> $stable(clk_sel));

endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  cfg_acc_t   acc,
    output dev_cfg_t   cfg,
    output logic [7:0] rd_data
);

    logic we;
    assign we = sel && acc.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (acc.idx)
                REG_ACTIVATE: cfg.active <= acc.wdata[0];
                REG_BASE_HI:  if (!cfg.active) cfg.base[15:8] <= acc.wdata;
                REG_BASE_LO:  if (!cfg.active) cfg.base[7:0]  <= acc.wdata;
                REG_OPTION:   cfg.opt <= acc.wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (acc.idx)
            REG_ACTIVATE: rd_data = {7'd0, cfg.active};
            REG_BASE_HI:  rd_data = cfg.base[15:8];
            REG_BASE_LO:  rd_data = cfg.base[7:0];
            REG_OPTION:   rd_data = cfg.opt;
            default:      rd_data = 8'h00;
        endcase
    end

    // R11: the base stays fixed across cycles in which the device is active
    assert_base_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg.active && $past(cfg.active)) |-> $stable(cfg.base));

    // R7: an unselected bank keeps its contents
    assert_unselected_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !sel |=> $stable(cfg));

endmodule

// File: rtl/sio_cfg_gate.sv
module sio_cfg_gate
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] BASE_PORT = 16'h002E,
    parameter int          NUM_DEV   = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_stb,
    input  logic                  rd_stb,
    input  logic                  port_sel,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    output logic                  rd_vld,
    output logic                  cfg_mode,
    output logic                  clk_div_sel,
    output logic [NUM_DEV-1:0]    dev_active,
    output logic [NUM_DEV*16-1:0] dev_base
);

    localparam int BASE_W = 16;

    logic       cfg_q;
    logic [7:0] idx_q;
    logic       key_wr, data_wr, unlock, leave;
    logic [7:0] dev_num, glob_rd, bank_rd;
    cfg_acc_t   glob_acc, bank_acc;
    dev_cfg_t   dev_cfg [NUM_DEV];
    logic [7:0] dev_rd  [NUM_DEV];

    assign key_wr  = wr_stb && !port_sel && !cfg_q;
    assign data_wr = wr_stb &&  port_sel &&  cfg_q;

    sio_key_matcher #(.BASE_PORT(BASE_PORT)) u_key (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (key_wr),
        .key_byte (wdata),
        .unlock   (unlock)
    );

    always_comb begin
        glob_acc.wr    = data_wr && !is_banked(idx_q);
        glob_acc.idx   = idx_q;
        glob_acc.wdata = wdata;
        bank_acc.wr    = data_wr && is_banked(idx_q);
        bank_acc.idx   = idx_q;
        bank_acc.wdata = wdata;
    end

    sio_global_regs u_glob (
        .clk     (clk),
        .rst     (rst),
        .acc     (glob_acc),
        .dev_num (dev_num),
        .clk_sel (clk_div_sel),
        .leave   (leave),
        .rd_data (glob_rd)
    );

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
        sio_dev_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .sel     (dev_num == 8'(i)),
            .acc     (bank_acc),
            .cfg     (dev_cfg[i]),
            .rd_data (dev_rd[i])
        );
        assign dev_active[i]                  = dev_cfg[i].active;
        assign dev_base[i*BASE_W +: BASE_W]   = dev_cfg[i].base;
    end

    always_comb begin
        bank_rd = 8'h00;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (dev_num == 8'(i)) bank_rd = dev_rd[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= 1'b0;
            idx_q <= 8'h00;
        end else begin
            if (unlock)     cfg_q <= 1'b1;
            else if (leave) cfg_q <= 1'b0;
            if (wr_stb && !port_sel && cfg_q) idx_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld <= 1'b0;
            rdata  <= 8'h00;
        end else begin
            rd_vld <= rd_stb;
            if (rd_stb) begin
                if (!cfg_q)         rdata <= LOCKED_BYTE;
                else if (!port_sel) rdata <= idx_q;
                else if (is_banked(idx_q)) rdata <= bank_rd;
                else                rdata <= glob_rd;
            end
        end
    end

    assign cfg_mode = cfg_q;

    // R2: the space opens only on an index write of the final key byte
    assert_open_on_key_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_q) |-> $past(wr_stb && !port_sel && wdata == last_key(BASE_PORT)));

    // R6: the space closes only on the leave code written to configure control
    assert_close_on_leave_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(cfg_q) && !$past(rst)) |->
            $past(wr_stb && port_sel && idx_q == REG_CFG_CTL && wdata == CFG_LEAVE));

    // R4: a locked read returns all ones
    assert_locked_read_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !cfg_q) |=> (rd_vld && rdata == LOCKED_BYTE));

    // R13: read valid follows the strobe by one cycle
    assert_rd_valid_follows_R13: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> rd_vld);
    assert_rd_valid_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> !rd_vld);

endmodule

// File: tb/sio_cfg_gate_tb.sv
module sio_cfg_gate_tb;

    localparam int NUM_DEV = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_stb = 1'b0, rd_stb = 1'b0, port_sel = 1'b0;
    logic [7:0] wdata = 8'h00;

    logic [7:0]            rdata, rdata_b;
    logic                  rd_vld, rd_vld_b;
    logic                  cfg_mode, cfg_mode_b;
    logic                  clk_div_sel, clk_div_sel_b;
    logic [NUM_DEV-1:0]    dev_active, dev_active_b;
    logic [NUM_DEV*16-1:0] dev_base, dev_base_b;

    always #4 clk = ~clk;

    sio_cfg_gate #(.BASE_PORT(16'h002E), .NUM_DEV(NUM_DEV)) u_dut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .port_sel(port_sel),
        .wdata(wdata), .rdata(rdata), .rd_vld(rd_vld), .cfg_mode(cfg_mode),
        .clk_div_sel(clk_div_sel), .dev_active(dev_active), .dev_base(dev_base)
    );

    sio_cfg_gate #(.BASE_PORT(16'h004E), .NUM_DEV(NUM_DEV)) u_dut_alt (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .port_sel(port_sel),
        .wdata(wdata), .rdata(rdata_b), .rd_vld(rd_vld_b), .cfg_mode(cfg_mode_b),
        .clk_div_sel(clk_div_sel_b), .dev_active(dev_active_b), .dev_base(dev_base_b)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [7:0] q_exp [$];
    string      q_tag [$];

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input bit ps, input logic [7:0] b);
        port_sel = ps; wdata = b; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd(input bit ps, input logic [7:0] e, input string tag);
        port_sel = ps; rd_stb = 1'b1;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic key(input logic [7:0] b3);
        wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55); wr(0, b3);
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] v);
        wr(0, idx); wr(1, v);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Scoreboard monitor: pops one expected byte for every valid read
    always @(negedge clk) begin
        if (!rst && rd_vld) begin
            n_chk++;
            if (q_exp.size() == 0) begin
                n_bad++;
                $display("FAIL R13: got unexpected read %0h expected no read", rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                if (rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: got %0h expected %0h", t, rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R13: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        chk("R1 cfg_mode", cfg_mode, 0);
        chk("R1 clk_div_sel", clk_div_sel, 0);
        chk("R1 dev_active", dev_active, 0);
        chk("R1 dev_base low", dev_base[31:0], 0);
        chk("R1 dev_base high", dev_base[127:96], 0);
        chk("R13 idle rd_vld", rd_vld, 0);

        rd(0, 8'hFF, "R4 locked index read");
        rd(1, 8'hFF, "R4 locked data read");
        wr(1, 8'h05);

        key(8'hAA);
        chk("R2 base 2E rejects AA", cfg_mode, 0);
        chk("R2 base 4E accepts AA", cfg_mode_b, 1);
        reg_wr(8'h02, 8'h02);
        chk("R6 alt instance leaves", cfg_mode_b, 0);

        wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h00); wr(0, 8'h55); wr(0, 8'h55);
        chk("R3 broken key stays locked", cfg_mode, 0);
        wr(0, 8'h87); wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55); wr(0, 8'h55);
        chk("R3 repeated first byte restarts", cfg_mode, 0);

        wr(0, 8'h12); wr(0, 8'h87); wr(1, 8'h33); wr(0, 8'h01); wr(0, 8'h55);
        chk("R2 not open before final byte", cfg_mode, 0);
        wr(0, 8'h55);
        chk("R2 R3 key opens after noise", cfg_mode, 1);
        chk("R2 alt stays locked on 55", cfg_mode_b, 0);

        wr(0, 8'h07);
        rd(0, 8'h07, "R5 index readback");
        rd(1, 8'h00, "R4 locked write discarded");
        wr(1, 8'h03);
        rd(1, 8'h03, "R7 device number readback");

        reg_wr(8'h23, 8'hFF);
        chk("R8 clk_div_sel set", clk_div_sel, 1);
        rd(1, 8'h01, "R8 only bit 0 stored");
        wr(1, 8'hFE);
        chk("R8 clk_div_sel cleared", clk_div_sel, 0);

        reg_wr(8'h25, 8'h5A);
        rd(1, 8'h00, "R9 other global reads zero");

        reg_wr(8'h60, 8'h12);
        reg_wr(8'h61, 8'h34);
        reg_wr(8'hF0, 8'hA5);
        reg_wr(8'h30, 8'hFF);
        chk("R10 dev_active", dev_active, 8'h08);
        chk("R10 dev_base", dev_base[63:48], 16'h1234);
        rd(1, 8'h01, "R10 activate readback");
        wr(0, 8'hF0);
        rd(1, 8'hA5, "R10 option readback");

        reg_wr(8'h60, 8'h99);
        chk("R11 base held while active", dev_base[63:48], 16'h1234);
        rd(1, 8'h12, "R11 base high unchanged");
        reg_wr(8'h30, 8'h00);
        chk("R10 device deactivated", dev_active, 8'h00);
        reg_wr(8'h60, 8'h99);
        reg_wr(8'h30, 8'h01);
        chk("R11 base written while inactive", dev_base[63:48], 16'h9934);

        reg_wr(8'h07, 8'h05);
        wr(0, 8'h60);
        rd(1, 8'h00, "R7 other bank separate");
        reg_wr(8'h61, 8'h77);
        chk("R7 bank 5 base", dev_base[95:80], 16'h0077);
        chk("R7 bank 3 base untouched", dev_base[63:48], 16'h9934);
        reg_wr(8'h07, 8'h03);
        wr(0, 8'h61);
        rd(1, 8'h34, "R7 bank 3 low byte");

        wr(0, 8'h45); wr(1, 8'h5A);
        rd(1, 8'h00, "R12 unmapped bank index");
        reg_wr(8'h07, 8'h09);
        reg_wr(8'h30, 8'h01);
        chk("R12 out of range device write", dev_active, 8'h08);
        rd(1, 8'h00, "R12 out of range device read");
        rd(1, 8'h00, "R13 back-to-back read");

        wr(0, 8'h02);
        rd(1, 8'h00, "R6 configure control reads zero");
        wr(1, 8'h01);
        chk("R6 other value ignored", cfg_mode, 1);
        wr(1, 8'h02);
        chk("R6 leave code locks", cfg_mode, 0);
        rd(0, 8'hFF, "R4 index read after leaving");
        rd(1, 8'hFF, "R4 data read after leaving");

        repeat (3) @(negedge clk);
        chk("R13 all reads answered", q_exp.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule